// File: doc/BRIEF.md
# 64b/66b Test Pattern Verifier

This block sits behind a descrambler in a 64b/66b receive path and checks that each received block carries the expected idle test pattern. Two patterns can be selected: a data block whose payload is all zeros, and a control block carrying a pair of local fault ordered sets. A block whose 64-bit payload is the bitwise inverse of the selected pattern, under the same sync header, also counts as correct. Every block that is neither is counted as a mismatch.

Checking happens only while the receive path reports block lock and the block is marked valid; anything else is ignored. Mismatches raise a one-cycle error pulse and advance a 16-bit counter that sticks at its top value until it is cleared. Both outputs update on the clock edge that samples the block, so they are visible one cycle after the block is presented.

Top module: `tpv_top`

## Requirements
- R1: After reset the mismatch count is 0 and the error pulse is low.
- R2: With pattern select 0, a block with sync header 2'b01 and payload 64'h0 is a match: no error pulse and no count change.
- R3: With pattern select 1, a block with sync header 2'b10 and payload 64'h00000100_0000014B (bits [7:0] block type 0x4B, bits [31:8] 0x000001, bits [39:32] 0x00, bits [63:40] 0x000001) is a match.
- R4: A block whose payload is the bitwise inverse of the selected pattern's payload, with the selected pattern's sync header, is a match.
- R5: A valid block sampled under lock that is not a match (wrong header or wrong payload) raises the error output in the following cycle and increments the count in that same cycle.
- R6: A block sampled while lock is low, or with valid low, causes no error pulse and leaves the count unchanged.
- R7: The count saturates at 16'hFFFF; further mismatches leave it there while still pulsing the error output.
- R8: A clear sampled high sets the count to 0 in the next cycle, taking priority over a mismatch in the same cycle, whose error pulse still fires.
- R9: The error output is high for exactly one cycle per counted mismatch, so back-to-back mismatches give a pulse for each cycle and it drops after the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| blk_hdr_i | input | 2 | Sync header of the incoming block |
| blk_pay_i | input | 64 | Descrambled payload of the incoming block |
| blk_vld_i | input | 1 | Block present this cycle |
| lock_i | input | 1 | Block lock status from the receive path |
| pat_sel_i | input | 1 | 0: all-zero data pattern, 1: local fault pattern |
| cnt_clr_i | input | 1 | Clear the mismatch count |
| err_o | output | 1 | One-cycle pulse per counted mismatch |
| mis_cnt_o | output | 16 | Saturating mismatch count |

## Verification
The assertions take for granted that reset is held low across at least one clock edge before use, and that the pattern select is stable and meaningful in every cycle a valid block is presented. They place no constraint on the timing of clear against mismatches, so the stimulus deliberately collides the two. The bench changes inputs only on the falling edge, keeps lock and valid at known levels throughout, and drives enough mismatches in a row to reach and hold saturation.

// File: rtl/tpv_pkg.sv
// Package: shared widths, pattern encodings and the expected-pattern builder
// for the 64b/66b test pattern verifier.
// Assumes: header value 2'b01 marks a data block and 2'b10 a control block.
package tpv_pkg;

    localparam int HDR_W = 2;
    localparam int PAY_W = 64;
    localparam int CNT_W = 16;
    localparam int HALF_W = PAY_W / 2;

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    localparam logic [7:0]  LF_BLK_TYPE = 8'h4B;
    localparam logic [7:0]  LF_ORD_CODE = 8'h00;
    localparam logic [23:0] LF_SEQ      = 24'h000001;

    typedef enum logic {
        PAT_ZERO   = 1'b0,
        PAT_LFAULT = 1'b1
    } pat_sel_e;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic [PAY_W-1:0] pay;
    } blk_t;

    // Build the local fault payload: lower half holds the block type and the
    // first sequence, upper half holds an order code and the second sequence.
    function automatic logic [PAY_W-1:0] lf_payload();
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        lo = {LF_SEQ, LF_BLK_TYPE};
        hi = {LF_SEQ, LF_ORD_CODE};
        return {hi, lo};
    endfunction

endpackage

// File: rtl/tpv_pattern_gen.sv
// Expected-pattern source.
// Does: maps the pattern select to the sync header and payload a correct
// block must carry. Purely combinational.
// Assumes: select is stable in any cycle a valid block is presented.
module tpv_pattern_gen
    import tpv_pkg::*;
(
    input  pat_sel_e sel_i,
    output blk_t     exp_o
);

    // Select the expected block for the chosen pattern.
    always_comb begin
        unique case (sel_i)
            PAT_LFAULT: begin
                exp_o.hdr = HDR_CTRL;
                exp_o.pay = lf_payload();
            end
            default: begin
                exp_o.hdr = HDR_DATA;
                exp_o.pay = '0;
            end
        endcase
    end

endmodule

// File: rtl/tpv_block_cmp.sv
// Block comparator.
// Does: decides whether a presented block is a counted mismatch. The header
// must equal the expected header; the payload may equal the expected payload
// or its bitwise inverse. Blocks outside lock or without valid never miss.
// Assumes: expected block is already resolved for this cycle.
module tpv_block_cmp
    import tpv_pkg::*;
(
    input  blk_t exp_i,
    input  blk_t blk_i,
    input  logic vld_i,
    input  logic lock_i,
    output logic miss_o
);

    logic hdr_ok;
    logic pay_true;
    logic pay_inv;
    logic active;

    // Compare header and both payload polarities.
    always_comb begin
        hdr_ok   = (blk_i.hdr == exp_i.hdr);
        pay_true = (blk_i.pay == exp_i.pay);
        pay_inv  = (blk_i.pay == ~exp_i.pay);
    end

    // Qualify with valid and lock to form the mismatch strobe.
    always_comb begin
        active = vld_i && lock_i;
        miss_o = active && !(hdr_ok && (pay_true || pay_inv));
    end

endmodule

// File: rtl/tpv_err_counter.sv
// Mismatch counter and error pulse.
// Does: registers a one-cycle error pulse per mismatch and a saturating
// count; clear beats a simultaneous increment.
// Assumes: synchronous active-low reset held for at least one edge.
module tpv_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             miss_i,
    input  logic             clr_i,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_max;

    // Flag the saturation point.
    always_comb at_max = (cnt_o == CNT_MAX);

    // Register the error pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) err_o <= 1'b0;
        else         err_o <= miss_i;
    end

    // Count mismatches with clear priority and saturation.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                cnt_o <= '0;
        else if (clr_i)             cnt_o <= '0;
        else if (miss_i && !at_max) cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/tpv_top.sv
// Test pattern verifier top.
// Does: checks each valid block under lock against the selected test
// pattern or its inverse, pulses err_o and counts each mismatch.
// Assumes: inputs are synchronous to clk_i; outputs lag the block by one cycle.
module tpv_top
    import tpv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       blk_hdr_i,
    input  logic [63:0]      blk_pay_i,
    input  logic             blk_vld_i,
    input  logic             lock_i,
    input  logic             pat_sel_i,
    input  logic             cnt_clr_i,
    output logic             err_o,
    output logic [15:0]      mis_cnt_o
);

    pat_sel_e sel;
    blk_t     exp_blk;
    blk_t     in_blk;
    logic     miss;

    // Pack the inputs into block form.
    always_comb begin
        sel        = pat_sel_e'(pat_sel_i);
        in_blk.hdr = blk_hdr_i;
        in_blk.pay = blk_pay_i;
    end

    tpv_pattern_gen u_gen (
        .sel_i (sel),
        .exp_o (exp_blk)
    );

    tpv_block_cmp u_cmp (
        .exp_i  (exp_blk),
        .blk_i  (in_blk),
        .vld_i  (blk_vld_i),
        .lock_i (lock_i),
        .miss_o (miss)
    );

    tpv_err_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .miss_i (miss),
        .clr_i  (cnt_clr_i),
        .err_o  (err_o),
        .cnt_o  (mis_cnt_o)
    );

endmodule

// File: rtl/tpv_checker.sv
// Checker for tpv_top: relates port behaviour across cycles.
// Assumes: reset held low for at least one edge before checks matter.
module tpv_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        blk_vld_i,
    input logic        lock_i,
    input logic        cnt_clr_i,
    input logic        err_o,
    input logic [15:0] mis_cnt_o
);

    AST_IGNORE_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!blk_vld_i || !lock_i) |=> !err_o); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_clr_i |=> (mis_cnt_o == 16'h0)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mis_cnt_o == 16'hFFFF) && !cnt_clr_i) |=> (mis_cnt_o == 16'hFFFF)); // R7

    AST_ERR_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !$past(cnt_clr_i) && ($past(mis_cnt_o) != 16'hFFFF))
        |-> (mis_cnt_o == $past(mis_cnt_o) + 16'h1)); // R5

    AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!err_o && !$past(cnt_clr_i)) |-> $stable(mis_cnt_o)); // R9

endmodule

bind tpv_top tpv_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blk_vld_i (blk_vld_i),
    .lock_i    (lock_i),
    .cnt_clr_i (cnt_clr_i),
    .err_o     (err_o),
    .mis_cnt_o (mis_cnt_o)
);

// File: tb/tpv_top_tb.sv
module tpv_top_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] LF_PAY = 64'h00000100_0000014B;

    typedef struct {
        logic        e;
        logic [15:0] c;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  hdr = 2'b01;
    logic [63:0] pay = '0;
    logic        vld = 1'b0;
    logic        lock = 1'b0;
    logic        sel = 1'b0;
    logic        clr = 1'b0;
    logic        err;
    logic [15:0] cnt;

    int   n_chk = 0;
    int   n_err = 0;
    int   model_cnt = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tpv_top u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .blk_hdr_i (hdr),
        .blk_pay_i (pay),
        .blk_vld_i (vld),
        .lock_i    (lock),
        .pat_sel_i (sel),
        .cnt_clr_i (clr),
        .err_o     (err),
        .mis_cnt_o (cnt)
    );

    // Driver: present one block per cycle and push the expected outputs.
    task automatic send(input logic [1:0] h, input logic [63:0] p,
                        input logic v, input logic lk, input logic s,
                        input logic c, input string tag);
        logic match;
        logic miss;
        exp_t it;
        @(negedge clk);
        hdr = h; pay = p; vld = v; lock = lk; sel = s; clr = c;
        match = s ? (h == 2'b10 && (p == LF_PAY || p == ~LF_PAY))
                  : (h == 2'b01 && (p == 64'h0 || p == ~64'h0));
        miss = v && lk && !match;
        if (c)                          model_cnt = 0;
        else if (miss && model_cnt < 65535) model_cnt++;
        it.e = miss; it.c = 16'(model_cnt); it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare outputs just after each edge against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                n_chk++;
                if (err !== it.e || cnt !== it.c) begin
                    n_err++;
                    $display("FAIL %s: err=%0b cnt=%0h expected err=%0b cnt=%0h",
                             it.tag, err, cnt, it.e, it.c);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 190000);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_chk++;
        if (err !== 1'b0 || cnt !== 16'h0) begin
            n_err++;
            $display("FAIL R1: err=%0b cnt=%0h expected err=0 cnt=0", err, cnt);
        end
        // R2 zero pattern matches
        send(2'b01, 64'h0, 1, 1, 0, 0, "R2");
        send(2'b01, 64'h0, 1, 1, 0, 0, "R2");
        // R3 local fault pattern matches
        send(2'b10, LF_PAY, 1, 1, 1, 0, "R3");
        // R4 inverses match
        send(2'b01, ~64'h0, 1, 1, 0, 0, "R4");
        send(2'b10, ~LF_PAY, 1, 1, 1, 0, "R4");
        // R5 mismatches: wrong header, bit flip, wrong pattern for select
        send(2'b10, 64'h0, 1, 1, 0, 0, "R5");
        send(2'b01, 64'h0000_0000_0001_0000, 1, 1, 0, 0, "R5");
        send(2'b10, LF_PAY, 1, 1, 0, 0, "R5");
        send(2'b01, LF_PAY, 1, 1, 1, 0, "R5");
        send(2'b01, 64'h0, 1, 1, 0, 0, "R9");
        // R6 unlocked or invalid blocks ignored
        send(2'b11, 64'hDEAD_BEEF, 1, 0, 0, 0, "R6");
        send(2'b11, 64'hDEAD_BEEF, 0, 1, 0, 0, "R6");
        send(2'b01, 64'h0, 0, 0, 0, 0, "R6");
        // R8 clear alone, then clear with a mismatch
        send(2'b01, 64'h0, 1, 1, 0, 1, "R8");
        send(2'b00, 64'h5, 1, 1, 0, 0, "R5");
        send(2'b00, 64'h5, 1, 1, 0, 1, "R8");
        // R7 saturation with back-to-back pulses (R9)
        for (int i = 0; i < 65540; i++)
            send(2'b11, 64'h1, 1, 1, 0, 0, "R7");
        send(2'b01, 64'h0, 1, 1, 0, 0, "R9");
        send(2'b01, 64'h0, 1, 1, 0, 1, "R8");
        send(2'b01, 64'h0, 0, 1, 0, 0, "R8");
        @(negedge clk);
        vld = 1'b0;
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule